// File: doc/BRIEF.md
# Bus Master Tenure Timer

This block decides how long a burst-capable bus master may keep the bus once the arbiter wants it back. Every transfer the master makes is a burst. A single access is simply a burst that stops after its first data phase. A configurable latency value sets a count of bus clocks. The count starts over each time the master begins a transaction. If the grant stays asserted, the burst runs until the data engine has no more data. If the grant is withdrawn, the master keeps going only until its own count reaches zero. It then ends the burst on the next data phase that completes.

The latency value is held in a register that counts in steps of eight clocks: its three lowest bits always read as zero. A build option swaps the register for a fixed read-only value of at most 16 clocks. That option suits masters that never run more than two data phases. Arbitration itself and the data path are outside this block. The block consumes the grant, a transaction-start strobe, a data-phase strobe and a continue request, and it produces the terminate pulse and the bus request.

Top module: `mstr_tenure_timer`

## Requirements
- R1: In the writable build the latency register reads zero after reset.
- R2: Bits 2..0 of the latency register always read zero, and writes to them are discarded. Bits 7..3 take the written value, so the timer resolution is 8 clocks.
- R3: The timer loads the latency value in the clock after `txn_start`. It then decrements once per clock while the transaction is open, and it stays at zero without wrapping.
- R4: While `gnt` is high and `burst_more` is high, `term` is never asserted, whatever the timer holds.
- R5: If `gnt` falls before the timer reaches zero, the burst continues until the first data phase at which the timer is zero.
- R6: When `gnt` is low and the timer is zero, the next completed data phase is terminated.
- R7: A latency value of zero counts as already expired, so losing the grant ends the burst at the next data phase.
- R8: A data phase completing with `burst_more` low is terminated, whatever the grant and timer hold. A single access therefore ends after one phase.
- R9: `term` is high only together with `dphase_done`, for exactly one clock per transaction.
- R10: `bus_req` is high while a transaction is open. After termination it follows `burst_more`, so the request stays up only if data is still pending.
- R11: In the fixed build the latency register reads the fixed value (16) and ignores writes. That value bounds tenure exactly as a written value would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_wr_en | input | 1 | Write strobe for the latency register |
| lat_wr_data | input | 8 | Write data for the latency register |
| lat_rd_data | output | 8 | Current latency register value |
| gnt | input | 1 | Bus grant from the arbiter, high = granted |
| txn_start | input | 1 | Master begins a transaction this clock |
| dphase_done | input | 1 | A data phase completes this clock |
| burst_more | input | 1 | Data engine wants to continue the burst |
| term | output | 1 | This completing data phase is the last one |
| bus_req | output | 1 | Bus request toward the arbiter |

## Verification
The main function is driven through a table of bursts, each one a triple of latency value, grant-removal clock and natural burst length. Bursts where the grant is never removed separate natural ends from timer ends. Bursts that lose the grant early against a large latency show that the timer, and not the grant, sets the end. Bursts that lose the grant after expiry show the grant edge setting the end. Zero and wraparound cases (latency zero, and a grant removed long after expiry) tell a saturating counter from a wrapping one. A second instance built with the fixed value runs the same stimulus, which tells the read-only variant apart from the writable one.

// File: rtl/mtt_pkg.sv
`timescale 1ns/1ps
package mtt_pkg;

   // Tenure state of the master
   typedef enum logic {
      TEN_IDLE = 1'b0,
      TEN_BUSY = 1'b1
   } ten_st_t;

   // Largest fixed read-only tenure allowed for short-burst masters
   localparam int unsigned FIXED_MAX = 16;

endpackage

// File: rtl/mtt_lat_reg.sv
`timescale 1ns/1ps
module mtt_lat_reg #(
   parameter int unsigned LAT_W     = 8,
   parameter int unsigned RO_LSB    = 3,
   parameter bit          FIXED_LAT = 1'b0,
   parameter int unsigned FIXED_VAL = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LAT_W-1:0] wr_data,
   output logic [LAT_W-1:0] lat_q
);

   localparam int unsigned HI_W = LAT_W - RO_LSB;

   if (RO_LSB < 1 || RO_LSB >= LAT_W) begin : g_bad_lsb
      $error("mtt_lat_reg: RO_LSB must lie in 1..LAT_W-1");
   end

   if (FIXED_LAT) begin : g_fixed
      if (FIXED_VAL > mtt_pkg::FIXED_MAX) begin : g_bad_val
         $error("mtt_lat_reg: fixed tenure exceeds the allowed maximum");
      end
      if ((FIXED_VAL % (1 << RO_LSB)) != 0) begin : g_bad_align
         $error("mtt_lat_reg: fixed tenure must be a multiple of the step");
      end
      logic unused_fixed;
      assign unused_fixed = ^{clk, rst_n, wr_en, wr_data};
      assign lat_q = LAT_W'(FIXED_VAL);
   end else begin : g_writable
      logic [HI_W-1:0] hi_q;
      logic            unused_lo;
      assign unused_lo = ^wr_data[RO_LSB-1:0];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q <= '0;
         end else if (wr_en) begin
            hi_q <= wr_data[LAT_W-1:RO_LSB];
         end
      end
      assign lat_q = {hi_q, {RO_LSB{1'b0}}};
   end

endmodule

// File: rtl/mtt_down_cnt.sv
`timescale 1ns/1ps
module mtt_down_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic [W-1:0] cnt_q,
   output logic         zero
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/mtt_tenure_ctl.sv
`timescale 1ns/1ps
module mtt_tenure_ctl
   import mtt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic txn_start,
   input  logic dphase_done,
   input  logic burst_more,
   input  logic gnt,
   input  logic expired,
   output logic busy,
   output logic term,
   output logic bus_req
);

   ten_st_t st_q;
   logic    preempt;
   logic    last_phase;

   assign busy       = (st_q == TEN_BUSY);
   assign preempt    = ~gnt & expired;
   assign last_phase = ~burst_more | preempt;
   assign term       = busy & dphase_done & last_phase;
   assign bus_req    = busy | burst_more;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= TEN_IDLE;
      end else if (txn_start) begin
         st_q <= TEN_BUSY;
      end else if (term) begin
         st_q <= TEN_IDLE;
      end
   end

endmodule

// File: rtl/mstr_tenure_timer.sv
`timescale 1ns/1ps
module mstr_tenure_timer #(
   parameter int unsigned LAT_W     = 8,
   parameter int unsigned RO_LSB    = 3,
   parameter bit          FIXED_LAT = 1'b0,
   parameter int unsigned FIXED_VAL = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lat_wr_en,
   input  logic [LAT_W-1:0] lat_wr_data,
   output logic [LAT_W-1:0] lat_rd_data,
   input  logic             gnt,
   input  logic             txn_start,
   input  logic             dphase_done,
   input  logic             burst_more,
   output logic             term,
   output logic             bus_req
);

   logic [LAT_W-1:0] lat_val;
   logic [LAT_W-1:0] cnt;
   logic             expired;
   logic             busy;

   mtt_lat_reg #(
      .LAT_W     (LAT_W),
      .RO_LSB    (RO_LSB),
      .FIXED_LAT (FIXED_LAT),
      .FIXED_VAL (FIXED_VAL)
   ) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lat_wr_en),
      .wr_data (lat_wr_data),
      .lat_q   (lat_val)
   );

   mtt_down_cnt #(
      .W (LAT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (txn_start),
      .load_val (lat_val),
      .run      (busy),
      .cnt_q    (cnt),
      .zero     (expired)
   );

   mtt_tenure_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .txn_start   (txn_start),
      .dphase_done (dphase_done),
      .burst_more  (burst_more),
      .gnt         (gnt),
      .expired     (expired),
      .busy        (busy),
      .term        (term),
      .bus_req     (bus_req)
   );

   assign lat_rd_data = lat_val;

endmodule

// File: rtl/mtt_chk.sv
`timescale 1ns/1ps
module mtt_chk #(
   parameter int unsigned LAT_W  = 8,
   parameter int unsigned RO_LSB = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LAT_W-1:0] lat_rd_data,
   input logic             gnt,
   input logic             txn_start,
   input logic             dphase_done,
   input logic             burst_more,
   input logic             term,
   input logic             bus_req,
   input logic [LAT_W-1:0] cnt,
   input logic             expired,
   input logic             busy
);

   a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lat_rd_data[RO_LSB-1:0] == '0);

   a_r3_cnt_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !txn_start) |=> (cnt == '0));

   a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !txn_start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   a_r4_hold_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt && burst_more) |-> !term);

   a_r6_end_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dphase_done && !gnt && expired) |-> term);

   a_r9_term_in_dphase: assert property (@(posedge clk) disable iff (!rst_n)
      term |-> dphase_done);

   a_r9_term_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> !term);

   a_r10_req_in_tenure: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> bus_req);

endmodule

bind mstr_tenure_timer mtt_chk #(
   .LAT_W  (LAT_W),
   .RO_LSB (RO_LSB)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lat_rd_data (lat_rd_data),
   .gnt         (gnt),
   .txn_start   (txn_start),
   .dphase_done (dphase_done),
   .burst_more  (burst_more),
   .term        (term),
   .bus_req     (bus_req),
   .cnt         (cnt),
   .expired     (expired),
   .busy        (busy)
);

// File: tb/mstr_tenure_timer_tb_top.sv
`timescale 1ns/1ps
module mstr_tenure_timer_tb_top;

   localparam int LW      = 8;
   localparam int FIX_VAL = 16;
   localparam int NVEC    = 9;
   localparam int MAXJ    = 61;

   // fields: written latency, first clock with grant low, natural length, expected end clock
   localparam int VEC [NVEC][4] = '{
      '{8'h0F, 100,  5,  5},   // R8 natural end, grant held
      '{8'h08, 100, 30, 30},   // R4 grant held past expiry
      '{8'h08,   3, 30,  9},   // R5 grant lost before expiry
      '{8'h17,  20, 40, 20},   // R6 expired before grant lost
      '{8'h07,   4, 30,  4},   // R7 zero latency
      '{8'h00, 100,  1,  1},   // R8 single access
      '{8'h18,   2, 10, 10},   // R8 natural end beats the timer
      '{8'h0F,   1, 30,  9},   // R5 grant lost at once
      '{8'h08,  50, 60, 50}    // R3 count holds at zero
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          lat_wr_en;
   logic [LW-1:0] lat_wr_data;
   logic          gnt, txn_start, dphase_done, burst_more;
   logic [LW-1:0] rd_m, rd_f;
   logic          term_m, term_f, req_m, req_f;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   mstr_tenure_timer #(.LAT_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
      .lat_rd_data(rd_m), .gnt(gnt), .txn_start(txn_start),
      .dphase_done(dphase_done), .burst_more(burst_more),
      .term(term_m), .bus_req(req_m)
   );

   mstr_tenure_timer #(.LAT_W(LW), .FIXED_LAT(1'b1), .FIXED_VAL(FIX_VAL)) dut_fix_i (
      .clk(clk), .rst_n(rst_n), .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
      .lat_rd_data(rd_f), .gnt(gnt), .txn_start(txn_start),
      .dphase_done(dphase_done), .burst_more(burst_more),
      .term(term_f), .bus_req(req_f)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic run_vec(input int v);
      int wv, g, n, e_m, e_f, t_m, t_f, c_m, c_f;
      int l_f;
      bit req_pending;
      wv  = VEC[v][0];
      g   = VEC[v][1];
      n   = VEC[v][2];
      e_m = VEC[v][3];
      l_f = (g > FIX_VAL + 1) ? g : FIX_VAL + 1;
      e_f = (n < l_f) ? n : l_f;
      // latency write
      @(negedge clk);
      lat_wr_en   = 1'b1;
      lat_wr_data = LW'(wv);
      @(negedge clk);
      lat_wr_en   = 1'b0;
      #1;
      check(rd_m == LW'(wv & 8'hF8), $sformatf("R2 readback vec%0d", v), rd_m, wv & 8'hF8);
      check(rd_f == LW'(FIX_VAL), $sformatf("R11 fixed readback vec%0d", v), rd_f, FIX_VAL);
      // transaction start
      @(negedge clk);
      gnt = 1'b1; burst_more = 1'b1; txn_start = 1'b1; dphase_done = 1'b0;
      t_m = 0; t_f = 0; c_m = 0; c_f = 0; req_pending = 1'b0;
      for (int j = 1; j <= MAXJ; j++) begin
         @(negedge clk);
         txn_start   = 1'b0;
         dphase_done = 1'b1;
         gnt         = (j < g);
         burst_more  = (j < n);
         #1;
         if (req_pending) begin
            check(req_m == (j < n), $sformatf("R10 request after end vec%0d", v), req_m, (j < n));
            req_pending = 1'b0;
         end
         if (term_m) begin
            c_m++;
            if (t_m == 0) begin
               t_m = j;
               req_pending = 1'b1;
            end
         end
         if (term_f) begin
            c_f++;
            if (t_f == 0) t_f = j;
         end
      end
      check(t_m == e_m, $sformatf("R3/R4/R5/R6/R7/R8 end clock vec%0d", v), t_m, e_m);
      check(t_f == e_f, $sformatf("R11 fixed end clock vec%0d", v), t_f, e_f);
      check(c_m == 1, $sformatf("R9 single pulse vec%0d", v), c_m, 1);
      check(c_f == 1, $sformatf("R9 fixed single pulse vec%0d", v), c_f, 1);
      @(negedge clk);
      dphase_done = 1'b0; burst_more = 1'b0; gnt = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #900000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; lat_wr_en = 1'b0; lat_wr_data = '0;
      gnt = 1'b1; txn_start = 1'b0; dphase_done = 1'b0; burst_more = 1'b0;
      // write during reset must not land
      @(negedge clk);
      lat_wr_en = 1'b1; lat_wr_data = 8'hF8;
      repeat (3) @(negedge clk);
      lat_wr_en = 1'b0;
      rst_n = 1'b1;
      #1;
      check(rd_m == '0, "R1 reset latency", rd_m, 0);
      check(rd_f == LW'(FIX_VAL), "R11 fixed value at reset", rd_f, FIX_VAL);
      check(term_m == 1'b0, "R9 no term at reset", term_m, 0);
      check(req_m == 1'b0, "R10 no request at reset", req_m, 0);
      // R2: only upper bits stick
      @(negedge clk);
      lat_wr_en = 1'b1; lat_wr_data = 8'hFF;
      @(negedge clk);
      lat_wr_en = 1'b0;
      #1;
      check(rd_m == 8'hF8, "R2 all-ones write", rd_m, 8'hF8);
      check(rd_f == LW'(FIX_VAL), "R11 fixed ignores write", rd_f, FIX_VAL);
      // R10: idle request follows pending data
      @(negedge clk);
      burst_more = 1'b1;
      #1;
      check(req_m == 1'b1, "R10 idle request with pending data", req_m, 1);
      @(negedge clk);
      burst_more = 1'b0;
      for (int v = 0; v < NVEC; v++) begin
         run_vec(v);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule